// File: doc/BRIEF.md
# Power-up Reset Time-out Sequencer

This block keeps a processor core in reset after a reset event until a chain of waits has run out, then raises one release signal. The chain depends on why the reset happened, on how the clock source is configured and on an active-low enable bit for a power-up timer. A power-up timer interval is counted in ticks of a separate low-frequency timebase. An oscillator start-up wait is counted in edges of the oscillator clock itself. The timer interval always comes first and the start-up wait follows it.

Power-on and brown-out pulses reset the sequencer asynchronously. The reset is released synchronously through a two-stage synchronizer, and the chain starts on the first clock edge after that. The external active-low reset pin does not restart the chain. It only gates the release. If the waits end while the pin is low, release follows on the first clock edge that samples the pin high. A wake-up request while running repeats the oscillator start-up wait for crystal modes and has no effect otherwise.

Top module: `rst_timeout_seq`

## Requirements
- R1: While the power-on or brown-out pulse is high, core_run_o is low.
- R2: With osc_mode_i = 2'b11 (RC, external or internal clock, no crystal) and tmr_en_n_i = 1, core_run_o rises on the third clock edge after the reset pulse falls.
- R3: With osc_mode_i = 2'b11 and tmr_en_n_i = 0, core_run_o stays low until PWRT_TICKS tick pulses have been sampled in the timer phase. It rises on the clock edge after the edge that samples the last tick.
- R4: With a crystal mode (osc_mode_i = 2'b00, 2'b01 or 2'b10) and tmr_en_n_i = 1, the start-up count begins on the third edge after the pulse falls. core_run_o rises OST_CYCLES + 1 edges after that, so with the default of 1024 it rises on edge 1028.
- R5: With a crystal mode and tmr_en_n_i = 0, the start-up count begins only after the timer interval ends. core_run_o rises OST_CYCLES + 2 edges after the edge that samples the last tick.
- R6: A brown-out pulse starts the same sequence as a power-on pulse.
- R7: If ext_rst_n_i is low when the waits end, core_run_o stays low. It rises on the first clock edge that samples ext_rst_n_i high.
- R8: While running, ext_rst_n_i low drops core_run_o on the next edge. When the pin returns high, core_run_o rises on the next edge without any waits being re-run.
- R9: In a crystal mode, a wake_req_i pulse while running drops core_run_o on the edge that samples it. core_run_o rises OST_CYCLES + 1 edges after that edge, and the power-up timer is not used even when it is enabled.
- R10: With osc_mode_i = 2'b11, a wake_req_i pulse while running leaves core_run_o high.
- R11: A new power-on or brown-out pulse during a countdown restarts the whole sequence from its beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock; also counts start-up edges |
| por_pulse_i | input | 1 | Power-on reset pulse, active high, asynchronous |
| bor_pulse_i | input | 1 | Brown-out reset pulse, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wake_req_i | input | 1 | Wake-up-from-sleep request, one clock pulse |
| osc_mode_i | input | 2 | 2'b00/2'b01/2'b10 crystal types, 2'b11 non-crystal |
| tmr_en_n_i | input | 1 | Power-up timer enable, 0 = enabled, 1 = disabled |
| slow_tick_i | input | 1 | Low-frequency timebase tick, one clock pulse |
| core_run_o | output | 1 | High releases the core from reset |

## Verification
The main function is driven by every combination of crystal versus non-crystal mode and timer enabled versus disabled. The release edge is checked exactly, and this separates a missing start-up count from a missing timer phase. In the crystal case with the timer on, a long gap is left before the last tick to show that the start-up count never overlaps the timer interval. Wake-ups in both mode families, with the timer enabled and no ticks supplied, show that only the start-up count is repeated. Pin holds before and after expiry, and a second power-on pulse mid-count, test gating against restart.

// File: rtl/rts_pkg.sv
package rts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PWRT = 2'd1,
        ST_OST  = 2'd2,
        ST_RUN  = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       run;
    } seq_regs_t;

    // Oscillator mode code that has no crystal start-up wait
    localparam logic [1:0] OSC_NONXTAL = 2'b11;

    function automatic logic is_crystal(input logic [1:0] mode);
        return mode != OSC_NONXTAL;
    endfunction

endpackage

// File: rtl/rts_rst_sync.sv
module rts_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_i,
    output logic rst_n_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or posedge arst_i) begin
        if (arst_i) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rts_evt_counter.sv
module rts_evt_counter #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic done_o
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign done_o = (cnt_q == W'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                cnt_d = '0;
        else if (inc_i && !done_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the wait counter saturates at its limit
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT));
endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
    import rts_pkg::*;
#(
    parameter int PWRT_TICKS  = 72,
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_osc,
    input  logic       por_pulse_i,
    input  logic       bor_pulse_i,
    input  logic       ext_rst_n_i,
    input  logic       wake_req_i,
    input  logic [1:0] osc_mode_i,
    input  logic       tmr_en_n_i,
    input  logic       slow_tick_i,
    output logic       core_run_o
);
    logic      rst_n;
    logic      xtal;
    logic      pwrt_done, ost_done;
    seq_regs_t regs_d, regs_q;

    assign xtal = is_crystal(osc_mode_i);

    rts_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_osc),
        .arst_i  (por_pulse_i | bor_pulse_i),
        .rst_n_o (rst_n)
    );

    rts_evt_counter #(.LIMIT(PWRT_TICKS)) u_pwrt (
        .clk    (clk_osc),
        .rst_n  (rst_n),
        .clr_i  (regs_q.state != ST_PWRT),
        .inc_i  (slow_tick_i),
        .done_o (pwrt_done)
    );

    rts_evt_counter #(.LIMIT(OST_CYCLES)) u_ost (
        .clk    (clk_osc),
        .rst_n  (rst_n),
        .clr_i  (regs_q.state != ST_OST),
        .inc_i  (1'b1),
        .done_o (ost_done)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (!tmr_en_n_i) regs_d.state = ST_PWRT;
                else if (xtal)   regs_d.state = ST_OST;
                else             regs_d.state = ST_RUN;
            end
            ST_PWRT: begin
                if (pwrt_done) regs_d.state = xtal ? ST_OST : ST_RUN;
            end
            ST_OST: begin
                if (ost_done) regs_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (wake_req_i && xtal) regs_d.state = ST_OST;
            end
            default: regs_d.state = ST_IDLE;
        endcase
        regs_d.run = (regs_d.state == ST_RUN) && ext_rst_n_i;
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: ST_IDLE, run: 1'b0};
        else        regs_q <= regs_d;
    end

    assign core_run_o = regs_q.run;

    // R7: release only follows an edge that saw the pin high
    assert_pin_gates_release_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $rose(core_run_o) |-> $past(ext_rst_n_i));

    // R8: pin low blocks release on the following edge
    assert_pin_low_blocks_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !ext_rst_n_i |=> !core_run_o);

    // R3: no release during the timer phase
    assert_pwrt_holds_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (regs_q.state == ST_PWRT) |-> !core_run_o);

    // R9: crystal wake-up takes the core back into reset
    assert_wake_drops_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (regs_q.state == ST_RUN && wake_req_i && xtal) |=> !core_run_o);

    // R10: non-crystal wake-up leaves the sequencer running
    assert_wake_ignored_R10: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (regs_q.state == ST_RUN && wake_req_i && !xtal) |=> (regs_q.state == ST_RUN));
endmodule

// File: tb/rst_timeout_seq_test.sv
module rst_timeout_seq_test;
    localparam int PT   = 5;
    localparam int OST  = 1024;
    localparam int SYNC = 2;
    localparam int LAT0 = SYNC + 1;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       bor = 1'b0;
    logic       ext_n = 1'b1;
    logic       wake = 1'b0;
    logic [1:0] mode = 2'b11;
    logic       en_n = 1'b1;
    logic       tick = 1'b0;
    logic       run;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    rst_timeout_seq #(.PWRT_TICKS(PT), .OST_CYCLES(OST), .SYNC_STAGES(SYNC)) uut (
        .clk_osc     (clk),
        .por_pulse_i (por),
        .bor_pulse_i (bor),
        .ext_rst_n_i (ext_n),
        .wake_req_i  (wake),
        .osc_mode_i  (mode),
        .tmr_en_n_i  (en_n),
        .slow_tick_i (tick),
        .core_run_o  (run)
    );

    task automatic chk(input string req, input logic exp);
        checks++;
        if (run !== exp) begin
            errors++;
            $display("FAIL %s: core_run_o=%b expected %b at %0t", req, run, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic give_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // drives a reset pulse; edges are counted from the negedge where it falls
    task automatic pulse(input logic use_bor);
        @(negedge clk);
        if (use_bor) bor = 1'b1; else por = 1'b1;
        #1;
        chk("R1", 1'b0);
        wait_n(2);
        chk("R1", 1'b0);
        if (use_bor) bor = 1'b0; else por = 1'b0;
    endtask

    task automatic t_nx_off();
        mode = 2'b11; en_n = 1'b1; ext_n = 1'b1;
        pulse(1'b0);
        wait_n(LAT0 - 1); chk("R2", 1'b0);
        wait_n(1);        chk("R2", 1'b1);
    endtask

    task automatic t_nx_on();
        mode = 2'b11; en_n = 1'b0;
        pulse(1'b0);
        wait_n(LAT0);
        for (int i = 0; i < PT - 1; i++) begin give_tick(); wait_n(3); end
        wait_n(20); chk("R3", 1'b0);
        give_tick(); chk("R3", 1'b0);
        wait_n(1);   chk("R3", 1'b1);
    endtask

    task automatic t_xt_off(input logic [1:0] m, input logic use_bor, input string req);
        mode = m; en_n = 1'b1;
        pulse(use_bor);
        wait_n(LAT0 + OST); chk(req, 1'b0);
        wait_n(1);          chk(req, 1'b1);
    endtask

    task automatic t_xt_on();
        mode = 2'b00; en_n = 1'b0;
        pulse(1'b0);
        wait_n(LAT0);
        for (int i = 0; i < PT - 1; i++) begin give_tick(); wait_n(2); end
        wait_n(OST + 100); chk("R5", 1'b0);
        give_tick();
        wait_n(OST + 1); chk("R5", 1'b0);
        wait_n(1);       chk("R5", 1'b1);
    endtask

    task automatic t_ext_hold();
        mode = 2'b11; en_n = 1'b1; ext_n = 1'b0;
        pulse(1'b0);
        wait_n(50); chk("R7", 1'b0);
        ext_n = 1'b1; #1; chk("R7", 1'b0);
        wait_n(1);        chk("R7", 1'b1);
    endtask

    task automatic t_ext_run();
        ext_n = 1'b0;
        wait_n(1);  chk("R8", 1'b0);
        wait_n(20); chk("R8", 1'b0);
        ext_n = 1'b1;
        wait_n(1);  chk("R8", 1'b1);
    endtask

    task automatic t_wake_xtal();
        mode = 2'b01; en_n = 1'b0;
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        chk("R9", 1'b0);
        wait_n(OST); chk("R9", 1'b0);
        wait_n(1);   chk("R9", 1'b1);
    endtask

    task automatic t_wake_nx();
        mode = 2'b11;
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        chk("R10", 1'b1);
        wait_n(5); chk("R10", 1'b1);
    endtask

    task automatic t_restart();
        mode = 2'b01; en_n = 1'b1;
        pulse(1'b0);
        wait_n(500); chk("R11", 1'b0);
        pulse(1'b0);
        wait_n(LAT0 + OST); chk("R11", 1'b0);
        wait_n(1);          chk("R11", 1'b1);
    endtask

    initial begin
        #2; chk("R1", 1'b0);
        wait_n(3); chk("R1", 1'b0);
        t_nx_off();
        t_nx_on();
        t_xt_off(2'b01, 1'b0, "R4");
        t_xt_on();
        t_xt_off(2'b10, 1'b1, "R6");
        t_ext_hold();
        t_ext_run();
        t_wake_xtal();
        t_wake_nx();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run=%b expected completion", run);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule